// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits between the host-side bus controls and the flash command sequencer. It decides whether a bus write cycle is real and may be passed on. A write cycle is recognised only when chip-enable and write-enable are both low, output-enable is high and the supply is reported healthy. That condition must also hold for enough clock cycles to rule out a glitch. The write counts when either enable is released. The block then raises a one-cycle acceptance strobe for the command sequencer.

It also guards an address window in the larger bank. While the write-protect input is low, qualified writes into the window are refused. A refused write sets a sticky violation flag. The protect level that applies to an operation is captured when the internal program or erase begins, which the sequencer signals with `op_active`. Any movement of the protect input while the operation runs is reported through the same sticky flag. Such movement does not change the captured decision. All inputs are assumed to be synchronous to `clk`, and `rst_n` is assumed to be released synchronously upstream.

Top module: `fwp_gate`

## Requirements
- R1: After reset both `wr_accept` and `prot_viol` are 0.
- R2: A write condition (`ce_n`=0, `we_n`=0, `oe_n`=1, `vdd_low`=0) held for at least MIN_W clock edges and then ended by raising `we_n` or `ce_n`, with `oe_n` still 1 and `vdd_low` still 0, makes `wr_accept` 1 in the cycle after the release. This holds when the target is not refused under R6.
- R3: A write condition held for fewer than MIN_W clock edges never produces `wr_accept`.
- R4: While `vdd_low` is 1, no write condition exists and no `wr_accept` follows.
- R5: With `oe_n` low, or with `ce_n` held high while `we_n` pulses, no `wr_accept` is produced.
- R6: A qualified write to an address in [PROT_BASE, PROT_BASE+PROT_SIZE) with `bank_big`=1 and effective protect level low is refused: `wr_accept` stays 0 and `prot_viol` is 1 from the next cycle.
- R7: With the effective protect level high (`wp_n`=1), qualified writes into the window are accepted.
- R8: With `bank_big`=0, window addresses are never refused, and neither is any address outside the window (for example PROT_BASE-1).
- R9: While `op_active` is 1, the effective protect level is the `wp_n` value of the last cycle with `op_active`=0. Any change of `wp_n` during `op_active` sets `prot_viol` in the next cycle.
- R10: Once set, `prot_viol` stays 1 until reset, and it does not block later writes outside the window.
- R11: `wr_accept` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| wp_n | input | 1 | Write protect, low protects the window |
| vdd_low | input | 1 | Supply below write threshold |
| op_active | input | 1 | Internal program/erase in progress |
| bank_big | input | 1 | Target address lies in the larger bank |
| addr | input | ADDR_W | Target word address |
| wr_accept | output | 1 | One-cycle strobe: write cycle accepted |
| prot_viol | output | 1 | Sticky protection violation flag |

## Verification
Write pulses are driven with lengths on both sides of MIN_W and ended by either enable. Each pulse is combined with output-enable low or supply low, so each inhibit is shown to suppress an otherwise valid cycle. Window addresses, the word just below the window, the top word and random addresses are tried with each protect level and bank flag. This separates the range compare, the bank qualifier and the protect input. A directed sequence toggles protect during an active operation, which tells the latched level apart from the live pin and shows that the violation is sticky.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // Half-open window test done one bit wider so the upper bound cannot wrap.
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] size);
    logic [32:0] hi;
    hi = {1'b0, base} + {1'b0, size};
    return (a >= base) && ({1'b0, a} < hi);
  endfunction
endpackage

// File: rtl/fwp_pulse_qual.sv
module fwp_pulse_qual #(
  parameter int MIN_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vdd_low,
  output logic end_ok
);
  localparam int CW = $clog2(MIN_W + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_W);

  logic          wr_low;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign wr_low = !ce_n && !we_n && oe_n && !vdd_low;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!wr_low) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != SAT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Release edge of a long-enough pulse, with no inhibit present at the edge.
  assign end_ok = (cnt_q == SAT) && (ce_n || we_n) && oe_n && !vdd_low;
endmodule

// File: rtl/fwp_region.sv
module fwp_region
  import fwp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int PROT_BASE = 'hFF000,
  parameter int PROT_SIZE = 4096
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_big,
  output logic              hit
);
  localparam logic [31:0] BASE32 = 32'(PROT_BASE);
  localparam logic [31:0] SIZE32 = 32'(PROT_SIZE);

  logic [31:0] addr32;
  assign addr32 = 32'(addr);
  assign hit    = bank_big && in_window(addr32, BASE32, SIZE32);
endmodule

// File: rtl/fwp_wp_track.sv
module fwp_wp_track (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  input  logic op_active,
  input  logic refuse,
  output logic wp_eff,
  output logic viol
);
  logic wp_lat_q, wp_lat_d, lat_en;
  logic viol_q, viol_d;

  always_comb begin
    lat_en   = !op_active;
    wp_lat_d = wp_n;
    viol_d   = viol_q | refuse | (op_active && (wp_n != wp_lat_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_lat_q <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      if (lat_en) wp_lat_q <= wp_lat_d;
      viol_q <= viol_d;
    end
  end

  assign wp_eff = op_active ? wp_lat_q : wp_n;
  assign viol   = viol_q;
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate #(
  parameter int ADDR_W    = 20,
  parameter int MIN_W     = 2,
  parameter int PROT_BASE = 'hFF000,
  parameter int PROT_SIZE = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              wp_n,
  input  logic              vdd_low,
  input  logic              op_active,
  input  logic              bank_big,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_accept,
  output logic              prot_viol
);
  logic end_ok, hit, wp_eff, refuse;
  logic acc_q, acc_d;

  fwp_pulse_qual #(.MIN_W(MIN_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .vdd_low(vdd_low), .end_ok(end_ok)
  );

  fwp_region #(.ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE)) u_region (
    .addr(addr), .bank_big(bank_big), .hit(hit)
  );

  fwp_wp_track u_wp (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .op_active(op_active),
    .refuse(refuse), .wp_eff(wp_eff), .viol(prot_viol)
  );

  always_comb begin
    refuse = end_ok && hit && !wp_eff;
    acc_d  = end_ok && !refuse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_d;
  end

  assign wr_accept = acc_q;
endmodule

// File: rtl/fwp_gate_chk.sv
module fwp_gate_chk #(
  parameter int ADDR_W    = 20,
  parameter int MIN_W     = 2,
  parameter int PROT_BASE = 'hFF000,
  parameter int PROT_SIZE = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              wp_n,
  input logic              vdd_low,
  input logic              op_active,
  input logic              bank_big,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_accept,
  input logic              prot_viol
);
  localparam int RW = $clog2(MIN_W + 1) + 1;
  logic [RW-1:0] run_q;
  logic          in_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!ce_n && !we_n && oe_n && !vdd_low) begin
      if (run_q < RW'(MIN_W)) run_q <= run_q + 1'b1;
    end else run_q <= '0;
  end

  assign in_win = (longint'(addr) >= longint'(PROT_BASE)) &&
                  (longint'(addr) < longint'(PROT_BASE) + longint'(PROT_SIZE));

  assert_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> ($past(run_q) >= RW'(MIN_W)));
  assert_supply_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vdd_low) |-> !wr_accept);
  assert_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!oe_n) |-> !wr_accept);
  assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> !($past(bank_big) && $past(in_win) && !$past(wp_n) && !$past(op_active)));
  assert_wp_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_active && $past(op_active) && (wp_n != $past(wp_n))) |=> prot_viol);
  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_viol |=> prot_viol);
  assert_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);
endmodule

bind fwp_gate fwp_gate_chk #(
  .ADDR_W(ADDR_W), .MIN_W(MIN_W), .PROT_BASE(PROT_BASE), .PROT_SIZE(PROT_SIZE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
  .vdd_low(vdd_low), .op_active(op_active), .bank_big(bank_big), .addr(addr),
  .wr_accept(wr_accept), .prot_viol(prot_viol)
);

// File: tb/fwp_gate_bench.sv
module fwp_gate_bench;
  localparam int AW    = 20;
  localparam int MINW  = 2;
  localparam int BASE  = 'hFF000;
  localparam int SIZE  = 4096;

  logic clk, rst_n, ce_n, we_n, oe_n, wp_n, vdd_low, op_active, bank_big;
  logic [AW-1:0] addr;
  logic wr_accept, prot_viol;
  int checks = 0, errors = 0;
  bit exp_viol = 0, done = 0;

  fwp_gate #(.ADDR_W(AW), .MIN_W(MINW), .PROT_BASE(BASE), .PROT_SIZE(SIZE)) u_fwp_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
    .vdd_low(vdd_low), .op_active(op_active), .bank_big(bank_big), .addr(addr),
    .wr_accept(wr_accept), .prot_viol(prot_viol)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic bit in_prot(input logic [AW-1:0] a, input logic big);
    return big && (int'(a) >= BASE) && (int'(a) < BASE + SIZE);
  endfunction

  function automatic bit qualifies(input int len, input bit oe_bad, input bit vdd_bad);
    return (len >= MINW) && !oe_bad && !vdd_bad;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; ce_n = 1; we_n = 1; oe_n = 1; wp_n = 1; vdd_low = 0;
    op_active = 0; bank_big = 0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    exp_viol = 0;
  endtask

  // One write pulse; wp_eff is the protect level the model applies.
  task automatic wcycle(input string req, input int len, input logic [AW-1:0] a,
                        input logic big, input logic wp, input logic wp_eff,
                        input bit use_ce, input bit oe_bad, input bit vdd_bad);
    bit q, exp_acc;
    @(negedge clk);
    addr = a; bank_big = big; wp_n = wp; oe_n = !oe_bad; vdd_low = vdd_bad;
    ce_n = 0; we_n = 0;
    repeat (len) @(negedge clk);
    if (use_ce) ce_n = 1; else we_n = 1;
    q = qualifies(len, oe_bad, vdd_bad);
    exp_acc = q && !(in_prot(a, big) && !wp_eff);
    if (q && !exp_acc) exp_viol = 1;
    @(negedge clk);
    chk(req, wr_accept, exp_acc);
    chk({req, " viol"}, prot_viol, exp_viol);
    ce_n = 1; we_n = 1; oe_n = 1; vdd_low = 0;
    @(negedge clk);
    chk("R11 single-cycle strobe", wr_accept, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    chk("R1 accept after reset", wr_accept, 1'b0);
    chk("R1 viol after reset", prot_viol, 1'b0);

    wcycle("R2 we release", MINW, 20'h00100, 1, 0, 0, 0, 0, 0);
    wcycle("R2 ce release", MINW + 3, 20'h12345, 0, 1, 1, 1, 0, 0);
    wcycle("R3 short pulse", MINW - 1, 20'h00100, 0, 1, 1, 0, 0, 0);
    wcycle("R3 zero pulse", 0, 20'h00100, 0, 1, 1, 0, 0, 0);
    wcycle("R4 supply low", MINW + 1, 20'h00200, 0, 1, 1, 0, 0, 1);
    wcycle("R5 oe low", MINW + 1, 20'h00300, 0, 1, 1, 0, 1, 0);

    // R5: ce_n held high while we_n pulses
    @(negedge clk); ce_n = 1; we_n = 0; addr = 20'h00400;
    repeat (MINW + 2) @(negedge clk);
    we_n = 1;
    @(negedge clk); chk("R5 ce high", wr_accept, 1'b0);

    wcycle("R8 below window", MINW, 20'(BASE - 1), 1, 0, 0, 0, 0, 0);
    wcycle("R8 small bank", MINW, 20'(BASE), 0, 0, 0, 0, 0, 0);
    wcycle("R7 wp high window", MINW, 20'hFFFFF, 1, 1, 1, 0, 0, 0);
    wcycle("R6 window base refused", MINW, 20'(BASE), 1, 0, 0, 0, 0, 0);
    wcycle("R6 window top refused", MINW, 20'hFFFFF, 1, 0, 0, 1, 0, 0);
    wcycle("R10 later write accepted", MINW, 20'h00010, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    chk("R10 viol held", prot_viol, 1'b1);

    // R9: latched protect level during an operation
    do_reset();
    @(negedge clk); wp_n = 1;
    @(negedge clk); op_active = 1;
    wcycle("R9 latched high, pin high", MINW, 20'(BASE + 5), 1, 1, 1, 0, 0, 0);
    chk("R9 no viol while stable", prot_viol, 1'b0);
    @(negedge clk); wp_n = 0;
    @(negedge clk); chk("R9 change flagged", prot_viol, 1'b1);
    exp_viol = 1;
    wcycle("R9 latched high, pin low", MINW, 20'(BASE + 5), 1, 0, 1, 0, 0, 0);
    @(negedge clk); op_active = 0;
    wcycle("R9 idle uses live pin", MINW, 20'(BASE + 5), 1, 0, 0, 0, 0, 0);

    // Random mix, operation idle
    do_reset();
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic big, wp;
      int len;
      bit oe_bad, vdd_bad, use_ce;
      case ($urandom % 4)
        0: a = 20'(BASE + ($urandom % SIZE));
        1: a = 20'(BASE - 1 - ($urandom % 16));
        2: a = 20'($urandom);
        default: a = 20'hFFFFF;
      endcase
      big = 1'($urandom); wp = 1'($urandom);
      len = $urandom % (MINW + 4);
      oe_bad = ($urandom % 8) == 0;
      vdd_bad = ($urandom % 8) == 0;
      use_ce = 1'($urandom);
      wcycle("R2/R6 random", len, a, big, wp, wp, use_ce, oe_bad, vdd_bad);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule